// File: doc/BRIEF.md
# ADC Sample-Phase Timer

This block times the sample phase of an analog-to-digital conversion. It holds two timing profiles. Each profile has a 5-bit base count and a 3-bit multiplier code. A 32-bit select vector has one bit per input channel, and that bit picks which profile the channel uses. The controller gives the block a channel number and a one-cycle start pulse. The block then holds `sampling` high for the computed number of clock cycles and follows it with a single-cycle `sample_done` pulse, which hands control to the later conversion steps.

All configuration is loaded in one write strobe. A write is refused while a sample phase is running, and also in a cycle where a start is being taken. A profile whose multiplier is x1 needs a base count of at least 3. A smaller value is raised to 3 when it is stored, and an error flag reports that this happened.

Top module: `adc_sample_timer`

## Requirements
- R1: For a channel whose selected profile has base count B and multiplier M, `sampling` stays high for exactly (B+1)*M+1 clock cycles. For example, B=9 with code 3'b001 gives 41 cycles.
- R2: Multiplier code 3'b000 means x1. Any code c from 1 to 7 means x2^(c+1), so the codes run x4, x8, x16, x32, x64, x128 and x256.
- R3: `sampling` rises in the cycle right after the clock edge that takes `start` while the block is idle. A `start` that arrives while `sampling` is high is ignored, and it neither lengthens nor repeats the phase.
- R4: `sample_done` is high for exactly one cycle, in the first cycle after the last high cycle of `sampling`.
- R5: Bit c of the select vector chooses the profile for channel c: 0 selects profile 0 and 1 selects profile 1.
- R6: After reset, both profiles hold base count 16 with code 3'b000 (18 cycles), all select bits are 0, and `sampling`, `sample_done` and `cfg_err` are low.
- R7: A `cfg_we` strobe taken while `sampling` is high, or in the same cycle as an accepted `start`, is ignored, and the previous profiles and select bits stay in effect.
- R8: An accepted write that gives a profile code 3'b000 and a base count below 3 stores base count 3 for that profile. `cfg_err` is then high from the next cycle until the next accepted write, and that next write clears it if neither of its profiles needs the clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration fields below |
| cfg_p0_base | input | 5 | Profile 0 base count |
| cfg_p0_code | input | 3 | Profile 0 multiplier code |
| cfg_p1_base | input | 5 | Profile 1 base count |
| cfg_p1_code | input | 3 | Profile 1 multiplier code |
| cfg_sel | input | 32 | Per-channel profile select |
| start | input | 1 | Start a sample phase |
| chan | input | 5 | Channel for the phase being started |
| sampling | output | 1 | High while the sample phase runs |
| sample_done | output | 1 | One-cycle pulse after the phase ends |
| cfg_err | output | 1 | The last accepted write needed clamping |

## Verification
Some properties are checked on every cycle:
- The stored profiles and select bits stay stable while a phase runs.
- The stored base count never falls below the x1 minimum.
- An idle start always raises `sampling`.
- `sample_done` only follows a high `sampling` and never lasts two cycles.
- The counter stays within the largest load.

The exact phase length for each code and channel, clamping, and the refusal of writes and restarts in the middle of a run can only be shown by the bench's scenarios. The bench measures those lengths at the ports.

// File: rtl/adc_sample_timer.sv
module adc_sample_timer #(
  parameter int NCH      = 32,
  parameter int BASE_W   = 5,
  parameter int CODE_W   = 3,
  parameter int MIN_BASE = 3,
  parameter int RST_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [BASE_W-1:0]      cfg_p0_base,
  input  logic [CODE_W-1:0]      cfg_p0_code,
  input  logic [BASE_W-1:0]      cfg_p1_base,
  input  logic [CODE_W-1:0]      cfg_p1_code,
  input  logic [NCH-1:0]         cfg_sel,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] chan,
  output logic                   sampling,
  output logic                   sample_done,
  output logic                   cfg_err
);
  localparam int CNT_W = BASE_W + (1 << CODE_W) + 1;
  localparam int SH_W  = CODE_W + 1;
  localparam logic [CNT_W-1:0] MAX_LOAD = CNT_W'((1 << BASE_W) << (1 << CODE_W));

  logic [BASE_W-1:0] p0_base_q, p1_base_q;
  logic [CODE_W-1:0] p0_code_q, p1_code_q;
  logic [NCH-1:0]    sel_q;
  logic              busy_q, done_q, err_q;
  logic [CNT_W-1:0]  cnt_q;

  wire accept = start && !busy_q;
  wire cfg_ok = cfg_we && !busy_q && !start;

  wire clamp0 = (cfg_p0_code == '0) && (cfg_p0_base < BASE_W'(MIN_BASE));
  wire clamp1 = (cfg_p1_code == '0) && (cfg_p1_base < BASE_W'(MIN_BASE));
  wire [BASE_W-1:0] w0_base = clamp0 ? BASE_W'(MIN_BASE) : cfg_p0_base;
  wire [BASE_W-1:0] w1_base = clamp1 ? BASE_W'(MIN_BASE) : cfg_p1_base;

  wire              use_p1  = sel_q[chan];
  wire [BASE_W-1:0] sel_base = use_p1 ? p1_base_q : p0_base_q;
  wire [CODE_W-1:0] sel_code = use_p1 ? p1_code_q : p0_code_q;
  wire [SH_W-1:0]   shift    = (sel_code == '0) ? '0 : SH_W'(sel_code) + SH_W'(1);
  wire [CNT_W-1:0]  load     = (CNT_W'(sel_base) + CNT_W'(1)) << shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_base_q <= BASE_W'(RST_BASE);
      p1_base_q <= BASE_W'(RST_BASE);
      p0_code_q <= '0;
      p1_code_q <= '0;
      sel_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_ok) begin
        p0_base_q <= w0_base;
        p1_base_q <= w1_base;
        p0_code_q <= cfg_p0_code;
        p1_code_q <= cfg_p1_code;
        sel_q     <= cfg_sel;
        err_q     <= clamp0 | clamp1;
      end
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= load;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign sampling    = busy_q;
  assign sample_done = done_q;
  assign cfg_err     = err_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(p0_base_q) && $stable(p1_base_q) && $stable(p0_code_q)
                && $stable(p1_code_q) && $stable(sel_q))); // R7
  AST_MIN_BASE0: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_code_q == '0) |-> (p0_base_q >= BASE_W'(MIN_BASE))); // R8
  AST_MIN_BASE1: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_code_q == '0) |-> (p1_base_q >= BASE_W'(MIN_BASE))); // R8
  AST_START_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sampling) |=> sampling); // R3
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_done) |-> $past(sampling)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |=> !sample_done); // R4
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= MAX_LOAD)); // R1
endmodule

// File: tb/tb_adc_sample_timer.sv
`timescale 1ns/1ps
module tb_adc_sample_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_p0_base = '0, cfg_p1_base = '0;
  logic [2:0]  cfg_p0_code = '0, cfg_p1_code = '0;
  logic [31:0] cfg_sel = '0;
  logic        start = 1'b0;
  logic [4:0]  chan = '0;
  logic        sampling, sample_done, cfg_err;

  int checks = 0, errors = 0;
  int m_b0 = 16, m_b1 = 16, m_c0 = 0, m_c1 = 0;
  logic [31:0] m_sel = '0;
  bit m_err = 0;

  always #2.5 clk = ~clk;

  adc_sample_timer dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mult_of(input int code);
    return (code == 0) ? 1 : (2 ** (code + 1));
  endfunction

  function automatic int eff_base(input int b, input int code);
    return (code == 0 && b < 3) ? 3 : b;
  endfunction

  function automatic int exp_len(input int ch);
    if (m_sel[ch]) return (m_b1 + 1) * mult_of(m_c1) + 1;
    return (m_b0 + 1) * mult_of(m_c0) + 1;
  endfunction

  task automatic wr(input int b0, input int c0, input int b1, input int c1, input logic [31:0] s);
    @(negedge clk);
    cfg_p0_base = 5'(b0); cfg_p0_code = 3'(c0);
    cfg_p1_base = 5'(b1); cfg_p1_code = 3'(c1);
    cfg_sel = s; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_err = (c0 == 0 && b0 < 3) || (c1 == 0 && b1 < 3);
    m_b0 = eff_base(b0, c0); m_b1 = eff_base(b1, c1);
    m_c0 = c0; m_c1 = c1; m_sel = s;
    chk(cfg_err == m_err, "R8 err flag", int'(cfg_err), int'(m_err));
  endtask

  // inject: 0 none, 1 config write mid-run, 2 extra start mid-run
  task automatic run(input int ch, input int inject, input string req);
    int n = 0;
    int exp = exp_len(ch);
    @(negedge clk);
    chan = 5'(ch); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sampling == 1'b1, "R3 rise after start", int'(sampling), 1);
    while (sampling && n < 10000) begin
      n++;
      if (n == 2 && inject == 1) begin
        cfg_p0_base = 5'd31; cfg_p0_code = 3'd6; cfg_p1_base = 5'd30;
        cfg_p1_code = 3'd6; cfg_sel = ~m_sel; cfg_we = 1'b1;
      end
      if (n == 2 && inject == 2) begin
        chan = 5'(ch ^ 1); start = 1'b1;
      end
      if (n == 3) begin cfg_we = 1'b0; start = 1'b0; end
      @(negedge clk);
    end
    chk(n == exp, req, n, exp);
    chk(sample_done == 1'b1, "R4 done after last cycle", int'(sample_done), 1);
    @(negedge clk);
    chk(sample_done == 1'b0, "R4 done one cycle", int'(sample_done), 0);
    chk(sampling == 1'b0, "R3 no restart", int'(sampling), 0);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int seed = $urandom(32'h5A17);
    seed = seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sampling && !sample_done && !cfg_err, "R6 reset outputs", int'({sampling, sample_done, cfg_err}), 0);
    run(5, 0, "R6 reset profile length");
    run(31, 0, "R6 reset select zero");

    wr(9, 1, 16, 0, 32'h0);
    run(0, 0, "R1 base 9 code 1 gives 41");

    for (int c = 0; c < 8; c++) begin
      wr(3, 0, 3, c, 32'hFFFF_FFFF);
      run(c, 0, "R2 multiplier code");
    end
    wr(5, 0, 31, 7, 32'h0000_0080);
    run(7, 0, "R2 largest length");
    run(6, 0, "R5 select bit zero");

    wr(4, 2, 7, 1, 32'h8000_0001);
    run(31, 0, "R5 top channel profile 1");
    run(0, 0, "R5 channel 0 profile 1");
    run(1, 0, "R5 channel 1 profile 0");

    run(0, 1, "R7 write during run");
    run(0, 0, "R7 old config kept");
    run(1, 0, "R7 old select kept");
    run(3, 2, "R3 start during run ignored");

    // write in the same cycle as an accepted start
    @(negedge clk);
    chan = 5'd1; start = 1'b1;
    cfg_p0_base = 5'd20; cfg_p0_code = 3'd3; cfg_we = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    while (sampling) @(negedge clk);
    @(negedge clk);
    run(1, 0, "R7 write with start ignored");

    wr(1, 0, 0, 0, 32'h0);
    run(2, 0, "R8 clamped length");
    wr(2, 1, 8, 0, 32'h0);
    run(2, 0, "R8 no clamp with x4");
    wr(8, 0, 2, 0, 32'hFFFF_FFFF);
    run(9, 0, "R8 profile 1 clamp");

    for (int i = 0; i < 25; i++) begin
      int b0 = int'($urandom % 32), b1 = int'($urandom % 32);
      int c0 = int'($urandom % 5),  c1 = int'($urandom % 5);
      logic [31:0] s = $urandom;
      wr(b0, c0, b1, c1, s);
      run(int'($urandom % 32), 0, "R1 random length");
      run(int'($urandom % 32), 0, "R5 random select");
    end
    finish_up();
  end
endmodule